// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Port with Selectable Slave-Select Source

This block is an SPI peripheral that moves one byte in each direction per transfer. It can act as the bus master, driving the serial clock and the MOSI line from a programmable division of the system clock, or as a slave that follows an external serial clock and answers on MISO. Data leaves most-significant bit first from a shift register, and the bits received replace it. All four clock polarity/phase combinations are available, and both ends of a link must use the same one.

The level the block treats as its slave select can come from the select pin or from a control bit written by software. When software owns it, the pin is disregarded and left free. The block watches that level. A master that sees its select driven low records a mode fault and drops back to slave operation. A slave that is written at a moment the clock phase forbids refuses the data and records a write collision. Software talks to the block through a small register port: a control register, a read-only status register and a data register, selected by a 2-bit address.

Register layout. Control register, address 0: bit0 enable, bit1 master, bit2 CPOL, bit3 CPHA, bits5:4 rate, bit6 software-select, bit7 software select level. Status register, address 1: bit7 transfer done, bit6 write collision, bit5 mode fault, bit0 currently master. Data register, address 2: a write loads the shift register, a read returns the last received byte.

Top module: `spi_ssm_ctrl`

## Requirements
- R1: After reset, the control, status and data registers read 0 and the sck_oe, mosi_oe and miso_oe outputs are 0.
- R2: In master mode (control bit0=1, bit1=1), a data write starts a transfer that sends the written byte MSB first on mosi_o and captures 8 bits from miso_i. Afterwards the data register returns the captured byte and status bit7 is 1. This holds for all four CPOL/CPHA settings.
- R3: With rate field value k (control bits5:4), each master SCK half period lasts 2^k system clocks, and sck_o rests at the CPOL value (control bit2) when no transfer runs.
- R4: In slave mode (bit0=1, bit1=0) with internal select low, the block shifts its loaded byte out MSB first on miso_o, timed by sck_i in the configured CPOL/CPHA mode. It receives a byte from mosi_i that the data register then returns, and sets status bit7.
- R5: When control bit6 is 1, the internal select level equals control bit7 and the ss_n_i pin has no effect. When bit6 is 0, the internal select level follows ss_n_i.
- R6: When the internal select is low while in master mode, status bit5 is set, control bit1 and status bit0 become 0, sck_oe and mosi_oe drop to 0, and any running transfer stops.
- R7: In slave mode with CPHA=0 (bit3=0), a data write while the internal select is low is refused (the shift register keeps its old byte) and status bit6 is set.
- R8: In slave mode with CPHA=1, a data write while the select is low but no bit of a byte has begun is accepted. A data write after the first clock edge of a byte and before its eighth bit is refused and sets status bit6.
- R9: Status bits 7, 6 and 5 stay set until a status read is followed by a data register access, which clears them.
- R10: A slave drives miso_oe high only while its internal select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; only needed for clearing side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Enable for sck_o |
| mosi_i | input | 1 | Serial data received as slave |
| mosi_o | output | 1 | Serial data sent as master |
| mosi_oe | output | 1 | Enable for mosi_o |
| miso_i | input | 1 | Serial data received as master |
| miso_o | output | 1 | Serial data sent as slave |
| miso_oe | output | 1 | Enable for miso_o |
| ss_n_i | input | 1 | Slave-select pin, active low |

## Verification
The assertions take for granted that an external serial clock toggles no faster than once every few system clocks, so that the synchronised slave edges never fall on consecutive cycles. They also assume software leaves CPOL alone while a master transfer runs. The bench holds each sck_i level for eight system clocks and changes mosi_i a full half period before the edge that samples it. It rewrites the control register only between transfers. Mode faults come only from the select pin or the software select bit, never from mid-transfer reconfiguration.

// File: rtl/spi_ssm_pkg.sv
package spi_ssm_pkg;

   // control register image, bit 7 down to bit 0
   typedef struct packed {
      logic       sel_lvl;   // bit7: select level used when sw_sel is set
      logic       sw_sel;    // bit6: select comes from sel_lvl instead of pin
      logic [1:0] rate;      // bits5:4: SCK half period = 2^rate clocks
      logic       cpha;      // bit3
      logic       cpol;      // bit2
      logic       mstr;      // bit1
      logic       en;        // bit0
   } spi_ctrl_t;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
   parameter int BITS   = 8,
   parameter int RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic [RATE_W-1:0] rate,
   input  logic              cpol,
   output logic              busy,
   output logic              sck,
   output logic              lead_ev,
   output logic              trail_ev,
   output logic              done_ev
);

   localparam int DIV_W  = 2 ** RATE_W;
   localparam int EDGE_W = $clog2(2 * BITS);
   localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * BITS - 1);

   if (RATE_W < 1 || RATE_W > 3) begin : g_bad_rate
      $error("spi_sck_gen: RATE_W must be 1..3");
   end

   logic [DIV_W-1:0]  div_q;
   logic [DIV_W-1:0]  half_last;
   logic [EDGE_W-1:0] edge_q;
   logic              phase_q;
   logic              busy_q;
   logic              tick;

   assign half_last = (DIV_W'(1) << rate) - DIV_W'(1);
   assign tick      = busy_q && (div_q == half_last);
   assign lead_ev   = tick && !phase_q;
   assign trail_ev  = tick && phase_q;
   assign done_ev   = trail_ev && (edge_q == LAST_EDGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
         div_q   <= '0;
         edge_q  <= '0;
      end else if (abort) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
         div_q   <= '0;
         edge_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            div_q  <= '0;
            edge_q <= '0;
         end
      end else if (tick) begin
         div_q   <= '0;
         phase_q <= ~phase_q;
         edge_q  <= edge_q + 1'b1;
         if (edge_q == LAST_EDGE) busy_q <= 1'b0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign busy = busy_q;
   assign sck  = cpol ^ phase_q;

   AST_SCK_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_ev |=> (sck == cpol)); // R3

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [BITS-1:0] load_data,
   input  logic            cpha,
   input  logic            lead,
   input  logic            trail,
   input  logic            abort,
   input  logic            rx_in,
   output logic            tx_bit,
   output logic [BITS-1:0] rx_data,
   output logic            byte_done,
   output logic            mid_byte
);

   localparam int CNT_W = $clog2(BITS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

   if (BITS < 2) begin : g_bad_bits
      $error("spi_shifter: BITS must be at least 2");
   end

   logic [BITS-1:0]  sr_q;
   logic [BITS-1:0]  rx_q;
   logic [BITS-1:0]  sr_next;
   logic [CNT_W-1:0] cnt_q;
   logic             hold_q;
   logic             out_q;
   logic             in_byte_q;

   // bit entering the register: captured now (phase 1) or held since lead (phase 0)
   assign sr_next   = {sr_q[BITS-2:0], (cpha ? rx_in : hold_q)};
   assign byte_done = trail && !abort && !load && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q      <= '0;
         rx_q      <= '0;
         cnt_q     <= '0;
         hold_q    <= 1'b0;
         out_q     <= 1'b0;
         in_byte_q <= 1'b0;
      end else begin
         if (load) begin
            sr_q  <= load_data;
            out_q <= load_data[BITS-1];
         end else if (lead && !abort) begin
            in_byte_q <= 1'b1;
            if (cpha) out_q  <= sr_q[BITS-1];
            else      hold_q <= rx_in;
         end else if (trail && !abort) begin
            sr_q <= sr_next;
            if (!cpha) out_q <= sr_q[BITS-2];
            if (cnt_q == LAST) begin
               cnt_q     <= '0;
               in_byte_q <= 1'b0;
               rx_q      <= sr_next;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         if (abort) begin
            cnt_q     <= '0;
            in_byte_q <= 1'b0;
         end
      end
   end

   assign tx_bit   = out_q;
   assign rx_data  = rx_q;
   assign mid_byte = in_byte_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done); // R2

endmodule

// File: rtl/spi_ss_guard.sv
module spi_ss_guard (
   input  logic en,
   input  logic mstr,
   input  logic cpha,
   input  logic sw_sel,
   input  logic sel_lvl,
   input  logic ss_pin,
   input  logic data_wr,
   input  logic mid_byte,
   input  logic mst_busy,
   output logic ss_int,
   output logic is_master,
   output logic is_slave,
   output logic modf_set,
   output logic wcol_set,
   output logic load_ok
);

   logic slave_locked;

   assign ss_int    = sw_sel ? sel_lvl : ss_pin;
   assign is_master = en && mstr;
   assign is_slave  = en && !mstr;
   assign modf_set  = is_master && !ss_int;

   // phase 0: select must be released before a reload; phase 1: only mid-byte locks
   assign slave_locked = cpha ? mid_byte : !ss_int;
   assign wcol_set     = data_wr && is_slave && slave_locked;
   assign load_ok      = data_wr && !wcol_set && !(is_master && mst_busy);

endmodule

// File: rtl/spi_ssm_ctrl.sv
module spi_ssm_ctrl #(
   parameter int BITS        = 8,
   parameter int RATE_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] bus_addr,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       sck_i,
   output logic       sck_o,
   output logic       sck_oe,
   input  logic       mosi_i,
   output logic       mosi_o,
   output logic       mosi_oe,
   input  logic       miso_i,
   output logic       miso_o,
   output logic       miso_oe,
   input  logic       ss_n_i
);
   import spi_ssm_pkg::*;

   if (BITS < 2 || BITS > 8) begin : g_bad_bits
      $error("spi_ssm_ctrl: BITS must be 2..8");
   end
   if (RATE_W != 2) begin : g_bad_rate
      $error("spi_ssm_ctrl: control register holds a 2-bit rate field");
   end

   spi_ctrl_t       ctrl_q;
   logic            done_q, wcol_q, modf_q, arm_q;
   logic            ss_s, sck_s, sck_d, mosi_s;
   logic            ss_int, is_master, is_slave, modf_set, wcol_set, load_ok;
   logic            data_wr, data_acc, clear_ev;
   logic            gen_busy, gen_sck, gen_lead, gen_trail, gen_done;
   logic            slv_act, slv_edge, slv_lead, slv_trail;
   logic            sh_lead, sh_trail, sh_abort, sh_done, sh_mid, sh_tx;
   logic [BITS-1:0] sh_rx;

   // ---------------- pin synchronisers ----------------
   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
      .clk(clk), .rst_n(rst_n), .d(ss_n_i), .q(ss_s));
   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));
   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d(mosi_i), .q(mosi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   // ---------------- register port ----------------
   assign data_wr  = bus_wr && (bus_addr == ADDR_DATA);
   assign data_acc = (bus_wr || bus_rd) && (bus_addr == ADDR_DATA);
   assign clear_ev = arm_q && data_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (bus_wr && bus_addr == ADDR_CTRL) ctrl_q <= spi_ctrl_t'(bus_wdata);
         if (modf_set) ctrl_q.mstr <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q  <= 1'b0;
         done_q <= 1'b0;
         wcol_q <= 1'b0;
         modf_q <= 1'b0;
      end else begin
         if (clear_ev)                              arm_q <= 1'b0;
         else if (bus_rd && bus_addr == ADDR_STAT)  arm_q <= 1'b1;
         done_q <= sh_done  | (done_q & ~clear_ev);
         wcol_q <= wcol_set | (wcol_q & ~clear_ev);
         modf_q <= modf_set | (modf_q & ~clear_ev);
      end
   end

   always_comb begin
      unique case (bus_addr)
         ADDR_CTRL: bus_rdata = ctrl_q;
         ADDR_STAT: bus_rdata = {done_q, wcol_q, modf_q, 4'b0000, is_master};
         ADDR_DATA: bus_rdata = 8'(sh_rx);
         default:   bus_rdata = 8'h00;
      endcase
   end

   // ---------------- select rules ----------------
   spi_ss_guard u_guard (
      .en(ctrl_q.en), .mstr(ctrl_q.mstr), .cpha(ctrl_q.cpha),
      .sw_sel(ctrl_q.sw_sel), .sel_lvl(ctrl_q.sel_lvl), .ss_pin(ss_s),
      .data_wr(data_wr), .mid_byte(sh_mid), .mst_busy(gen_busy),
      .ss_int(ss_int), .is_master(is_master), .is_slave(is_slave),
      .modf_set(modf_set), .wcol_set(wcol_set), .load_ok(load_ok));

   // ---------------- master clock ----------------
   spi_sck_gen #(.BITS(BITS), .RATE_W(RATE_W)) u_sck_gen (
      .clk(clk), .rst_n(rst_n),
      .start(load_ok && is_master), .abort(modf_set || !is_master),
      .rate(ctrl_q.rate), .cpol(ctrl_q.cpol),
      .busy(gen_busy), .sck(gen_sck),
      .lead_ev(gen_lead), .trail_ev(gen_trail), .done_ev(gen_done));

   // ---------------- slave edge detection ----------------
   assign slv_act   = is_slave && !ss_int;
   assign slv_edge  = slv_act && (sck_s != sck_d);
   assign slv_lead  = slv_edge && (sck_s != ctrl_q.cpol);
   assign slv_trail = slv_edge && (sck_s == ctrl_q.cpol);

   assign sh_lead  = is_master ? gen_lead  : slv_lead;
   assign sh_trail = is_master ? gen_trail : slv_trail;
   assign sh_abort = !ctrl_q.en || modf_set || (is_slave && ss_int);

   // ---------------- shift register ----------------
   spi_shifter #(.BITS(BITS)) u_shifter (
      .clk(clk), .rst_n(rst_n),
      .load(load_ok), .load_data(bus_wdata[BITS-1:0]), .cpha(ctrl_q.cpha),
      .lead(sh_lead), .trail(sh_trail), .abort(sh_abort),
      .rx_in(is_master ? miso_i : mosi_s),
      .tx_bit(sh_tx), .rx_data(sh_rx), .byte_done(sh_done), .mid_byte(sh_mid));

   // ---------------- pins ----------------
   assign sck_o   = gen_sck;
   assign sck_oe  = is_master;
   assign mosi_o  = sh_tx;
   assign mosi_oe = is_master;
   assign miso_o  = sh_tx;
   assign miso_oe = slv_act;

   AST_MODF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      modf_set |=> !ctrl_q.mstr); // R6
   AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wcol_q && !clear_ev) |=> wcol_q); // R9
   AST_SLAVE_BYTE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_done && !is_master) |-> !ss_int); // R4
   AST_MASTER_DONE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_done && is_master && !modf_set) |-> sh_done); // R2

endmodule

// File: tb/test_spi_ssm_ctrl.sv
module test_spi_ssm_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00, bus_rdata;
   logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
   logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

   int tests = 0, fails = 0;

   always #5 clk = ~clk;

   spi_ssm_ctrl i_spi_ssm_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
      .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i));

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] cfg(input logic lvl, input logic sw, input logic [1:0] rate,
                                      input logic cpha, input logic cpol, input logic mstr);
      return {lvl, sw, rate, cpha, cpol, mstr, 1'b1};
   endfunction

   // ---------------- bench-side slave for master tests ----------------
   logic       m_on = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;
   logic [7:0] bs_tx = 8'h00, bs_rx = 8'h00;
   logic       bs_hold = 1'b0;

   always @(sck_o) begin
      if (m_on && sck_oe) begin
         if (sck_o != m_cpol) begin           // leading edge
            if (!m_cpha) bs_hold = mosi_o;
            else         miso_i  = bs_tx[7];
         end else begin                        // trailing edge
            if (!m_cpha) begin
               bs_rx = {bs_rx[6:0], bs_hold};
               bs_tx = {bs_tx[6:0], 1'b0};
               miso_i = bs_tx[7];
            end else begin
               bs_rx = {bs_rx[6:0], mosi_o};
               bs_tx = {bs_tx[6:0], 1'b0};
            end
         end
      end
   end

   task automatic wait_done(output logic [7:0] st);
      st = 8'h00;
      for (int i = 0; i < 400 && !st[7]; i++) bus_read(2'd1, st);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      logic [7:0] d;
      bus_read(2'd0, d); chk("R1 control after reset", d, 0);
      bus_read(2'd1, d); chk("R1 status after reset", d, 0);
      bus_read(2'd2, d); chk("R1 data after reset", d, 0);
      chk("R1 output enables after reset", {sck_oe, mosi_oe, miso_oe}, 0);
   endtask

   task automatic t_master(input logic cpol, input logic cpha, input logic [1:0] rate,
                           input logic [7:0] dut_tx, input logic [7:0] ext_tx);
      logic [7:0] st, d;
      ss_n_i = 1'b1;
      bus_write(2'd0, cfg(1'b1, 1'b1, rate, cpha, cpol, 1'b1));
      idle(2);
      chk("R3 sck idles at CPOL", sck_o, cpol);
      m_cpol = cpol; m_cpha = cpha; bs_tx = ext_tx; bs_rx = 8'h00;
      miso_i = ext_tx[7];
      m_on = 1'b1;
      bus_write(2'd2, dut_tx);
      wait_done(st);
      m_on = 1'b0;
      chk($sformatf("R2 done flag mode %0d%0d", cpol, cpha), st[7], 1);
      bus_read(2'd2, d);
      chk($sformatf("R2 master received mode %0d%0d", cpol, cpha), d, ext_tx);
      chk($sformatf("R2 master sent mode %0d%0d", cpol, cpha), bs_rx, dut_tx);
      bus_read(2'd1, st);
      chk("R9 done cleared by status read then data read", st[7], 0);
   endtask

   task automatic t_rate(input logic [1:0] rate);
      logic [7:0] st, d;
      time t1, t2;
      bus_write(2'd0, cfg(1'b1, 1'b1, rate, 1'b0, 1'b0, 1'b1));
      bus_write(2'd2, 8'h55);
      @(sck_o); t1 = $time;
      @(sck_o); t2 = $time;
      chk($sformatf("R3 half period clocks rate %0d", rate), int'((t2 - t1) / 10), 1 << rate);
      wait_done(st);
      bus_read(2'd2, d);
   endtask

   localparam int HP = 8;

   task automatic t_slave(input logic cpol, input logic cpha, input logic sw,
                          input logic [7:0] dut_tx, input logic [7:0] ext_tx);
      logic [7:0] st, d, got;
      got = 8'h00;
      ss_n_i = 1'b1; sck_i = cpol;
      bus_write(2'd0, cfg(1'b1, sw, 2'd0, cpha, cpol, 1'b0));
      bus_write(2'd2, dut_tx);
      if (sw) bus_write(2'd0, cfg(1'b0, 1'b1, 2'd0, cpha, cpol, 1'b0));
      else    ss_n_i = 1'b0;
      idle(6);
      chk("R10 miso driven while selected", miso_oe, 1);
      for (int i = 7; i >= 0; i--) begin
         if (!cpha) begin
            mosi_i = ext_tx[i]; idle(HP);
            got[i] = miso_o; sck_i = ~cpol; idle(HP);
            sck_i = cpol;
         end else begin
            idle(HP); sck_i = ~cpol; mosi_i = ext_tx[i];
            idle(HP); got[i] = miso_o; sck_i = cpol;
         end
      end
      idle(HP);
      if (sw) bus_write(2'd0, cfg(1'b1, 1'b1, 2'd0, cpha, cpol, 1'b0));
      else    ss_n_i = 1'b1;
      idle(6);
      chk("R10 miso released when deselected", miso_oe, 0);
      bus_read(2'd1, st);
      chk($sformatf("R4 slave done mode %0d%0d sw %0d", cpol, cpha, sw), st[7], 1);
      bus_read(2'd2, d);
      chk($sformatf("R4 slave received mode %0d%0d sw %0d", cpol, cpha, sw), d, ext_tx);
      chk($sformatf("R4 slave sent mode %0d%0d sw %0d", cpol, cpha, sw), got, dut_tx);
   endtask

   task automatic t_wcol_phase0;
      logic [7:0] st, d;
      ss_n_i = 1'b1; sck_i = 1'b0;
      bus_write(2'd0, cfg(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0));
      bus_write(2'd2, 8'hA5);
      ss_n_i = 1'b0; idle(6);
      bus_write(2'd2, 8'h3C);
      idle(2);
      bus_read(2'd1, st);
      chk("R7 collision flag on write with select low", st[6], 1);
      chk("R7 refused write keeps old first bit", miso_o, 1);
      bus_read(2'd2, d);
      bus_read(2'd1, st);
      chk("R9 collision cleared by status read then data read", st[6], 0);
      ss_n_i = 1'b1; idle(6);
      bus_write(2'd2, 8'h3C);
      ss_n_i = 1'b0; idle(6);
      chk("R7 write accepted with select high", miso_o, 0);
      bus_read(2'd1, st);
      chk("R7 no collision with select high", st[6], 0);
      ss_n_i = 1'b1; idle(6);
   endtask

   task automatic t_wcol_phase1;
      logic [7:0] st, d;
      ss_n_i = 1'b1; sck_i = 1'b0;
      bus_write(2'd0, cfg(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0));
      bus_write(2'd2, 8'h81);
      ss_n_i = 1'b0; idle(6);
      bus_write(2'd2, 8'h42);
      bus_read(2'd1, st);
      chk("R8 write between bytes accepted", st[6], 0);
      sck_i = 1'b1; idle(HP);
      chk("R8 accepted byte appears at leading edge", miso_o, 0);
      bus_write(2'd2, 8'hFF);
      idle(2);
      bus_read(2'd1, st);
      chk("R8 collision flag mid-byte", st[6], 1);
      chk("R8 refused mid-byte write leaves output", miso_o, 0);
      sck_i = 1'b0; ss_n_i = 1'b1; idle(6);
      bus_read(2'd2, d);
   endtask

   task automatic t_modf;
      logic [7:0] st, d;
      ss_n_i = 1'b1;
      bus_write(2'd0, cfg(1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1));
      idle(4);
      bus_read(2'd1, st);
      chk("R6 master active with pin high", st[0], 1);
      bus_write(2'd2, 8'h99);
      idle(10);
      ss_n_i = 1'b0; idle(6);
      bus_read(2'd1, st);
      chk("R6 mode fault flag", st[5], 1);
      chk("R6 no longer master", st[0], 0);
      bus_read(2'd0, d);
      chk("R6 master bit cleared", d[1], 0);
      chk("R6 clock and mosi released", {sck_oe, mosi_oe}, 0);
      bus_read(2'd2, d);
      bus_read(2'd1, st);
      chk("R9 mode fault cleared", st[5], 0);
      // software select keeps a master alive with the pin low
      bus_write(2'd0, cfg(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1));
      idle(6);
      bus_read(2'd1, st);
      chk("R5 pin ignored under software select", {st[5], st[0]}, 1);
      ss_n_i = 1'b1;
   endtask

   // ---------------- run ----------------
   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_master(1'b0, 1'b0, 2'd0, 8'hB4, 8'h5A);
      t_master(1'b0, 1'b1, 2'd1, 8'h81, 8'h7E);
      t_master(1'b1, 1'b0, 2'd0, 8'h0F, 8'hC3);
      t_master(1'b1, 1'b1, 2'd2, 8'hE7, 8'h18);
      t_rate(2'd2);
      t_rate(2'd3);
      t_slave(1'b0, 1'b0, 1'b0, 8'hC9, 8'h36);
      t_slave(1'b0, 1'b1, 1'b0, 8'h6D, 8'hA2);
      t_slave(1'b1, 1'b0, 1'b0, 8'h1E, 8'hF0);
      t_slave(1'b1, 1'b1, 1'b1, 8'h93, 8'h4C);  // R5: select from software, pin high
      t_wcol_phase0();
      t_wcol_phase1();
      t_modf();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1_500_000;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule